// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical address by searching a hashed page table that lives in ordinary memory. A request carries the address and a user/supervisor flag. The walker picks one of sixteen segment entries using the top nibble of the address. It hashes the segment's virtual segment number with the page index to find a 64-byte group of eight two-word entries. It then reads the entries over a word-read memory port until one carries the expected tag and grants some access.

When the first group holds no usable entry, the walker searches a second group. That group is found by complementing the hash, and its tag has a distinguishing bit set. A successful search reports the physical address with read and write permission. Before the walker reports completion, it updates the entry's referenced flag and changed flag in memory with single-byte writes. When neither group holds a usable entry, it reports a fault.

The block sits between a core's miss handling and the memory system. It handles one walk at a time and accepts work only while it is idle.

Top module: `hpt_walker`

## Requirements
- R1: After reset `reqReady` is 1, and `walkDone` and `memReq` are 0. A request is accepted only while `reqReady` is 1. `reqReady` stays 0 from acceptance until the cycle after the one-cycle `walkDone` pulse.
- R2: Each segment entry is 30 bits wide. Bit 29 is the supervisor key, bit 28 is the user key and bits 27:0 are the virtual segment number. The entry is selected by address bits 31:28. The primary group address is `{tableBase,16'h0} | (((vsn ^ ea[27:12]) << 6) & {7'b0,tableMask,16'hFFC0})`, computed in 32 bits.
- R3: The expected tag is `32'h8000_0000 | (vsn << 7) | (secondary << 6) | ea[27:22]`. Entry i occupies the words at group+8i (tag) and group+8i+4 (second word). Entries are tried from 0 upward, and the first usable match wins.
- R4: On a hit, `physAddr` is the second word with bits 11:0 replaced by `ea[11:0]`.
- R5: A 3-bit code is formed as `{key, word2[1:0]}`. The key is the user key in user mode and the supervisor key in supervisor mode. Codes 0, 1, 2 and 6 give read and write. Codes 3, 5 and 7 give read only. `canWrite` is never 1 without `canRead`.
- R6: A matching entry with code 4 is passed over, and the search goes on with the next entry.
- R7: Only after all eight primary entries fail does the walker search the secondary group. That group's address uses the bitwise complement of the shifted hash before the mask, and its tag has bit 6 set.
- R8: When both groups fail, `walkDone` and `walkFault` pulse together with `canRead` and `canWrite` at 0. Exactly 16 tag words have been read.
- R9: The memory is byte-addressed and big-endian, so byte offset 2 of a word is bits 15:8 and offset 3 is bits 7:0. On a hit whose referenced flag (bit 8) is clear, the walker writes byte offset 2 of the second word with that byte's old value ORed with 8'h01.
- R10: On a writable hit whose changed flag (bit 7) is clear, the walker writes byte offset 3 with the old low byte ORed with 8'h80. This write comes after any referenced-flag write, and a read-only hit never issues it.
- R11: A hit whose needed flags are already set causes no memory write.
- R12: Once raised, `memReq` holds with `memAddr`, `memWrite` and `memWdata` stable until the cycle in which `memAck` is 1. Results do not depend on memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Walk request |
| reqReady | output | 1 | Walker idle, request may be taken |
| reqAddr | input | 32 | Effective address to translate |
| reqUser | input | 1 | 1 = user mode, 0 = supervisor |
| segTable | input | 480 | Sixteen 30-bit segment entries, entry n at bits 30n+29:30n |
| tableBase | input | 16 | Upper 16 bits of the table base |
| tableMask | input | 9 | Hash mask bits placed at 24:16 |
| memReq | output | 1 | Memory access request |
| memWrite | output | 1 | 1 = byte write, 0 = word read |
| memAddr | output | 32 | Byte address of the access |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 32 | Read word, valid with memAck |
| memAck | input | 1 | Access complete |
| walkDone | output | 1 | One-cycle completion pulse |
| walkFault | output | 1 | Completion without translation |
| physAddr | output | 32 | Translated address, valid with walkDone |
| canRead | output | 1 | Read permitted, valid with walkDone |
| canWrite | output | 1 | Write permitted, valid with walkDone |

## Verification
The bench builds the walker with its default of eight entries per group and sixteen segment entries. This makes the last-entry boundary and the step from primary to secondary group reachable within seventeen reads. One scenario sets all nine mask bits with a disjoint base, so the upper hash bits reach the address bus, while the others keep the mask zero. The bench memory's acknowledge latency is raised from one to three cycles in one scenario, to show that results and write order do not change under a slower port.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
  localparam int WORD_W    = 32;
  localparam int SEG_W     = 30;
  localparam int SEG_COUNT = 16;
  localparam int REF_BIT   = 8;
  localparam int CHG_BIT   = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_COMPARE, ST_WRITEBACK, ST_DONE, ST_FAULT
  } walkState_t;

  typedef enum logic [1:0] {MA_READ, MA_REF, MA_CHG} memAddrSel_t;

  typedef struct packed {
    logic        start;
    logic        capture;
    logic        toLow;
    logic        nextEntry;
    logic        toSecondary;
    memAddrSel_t addrSel;
  } walkCtl_t;

  typedef struct packed {
    logic tagMatch;
    logic permNone;
    logic needRef;
    logic needChg;
    logic lastEntry;
    logic onSecondary;
    logic wordIsLow;
  } walkStat_t;

  // returns {read, write}
  function automatic logic [1:0] decodePerm(input logic [2:0] code);
    logic [1:0] r;
    case (code)
      3'd0, 3'd1, 3'd2, 3'd6: r = 2'b11;
      3'd3, 3'd5, 3'd7:       r = 2'b10;
      default:                r = 2'b00;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/hpt_dpath.sv
`timescale 1ns/1ps
module hpt_dpath import hpt_pkg::*; #(
  parameter int GROUP_ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  walkCtl_t                   ctl,
  output walkStat_t                  stat,
  input  logic [WORD_W-1:0]          reqAddr,
  input  logic                       reqUser,
  input  logic [SEG_COUNT*SEG_W-1:0] segTable,
  input  logic [15:0]                tableBase,
  input  logic [8:0]                 tableMask,
  input  logic [WORD_W-1:0]          memRdata,
  output logic [WORD_W-1:0]          memAddr,
  output logic [7:0]                 memWdata,
  output logic [WORD_W-1:0]          physAddr,
  output logic                       permRead,
  output logic                       permWrite
);
  localparam int ENTRY_W     = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
  localparam int ENTRY_SHIFT = 3;   // two 32-bit words per entry
  localparam int LAST_ENTRY  = GROUP_ENTRIES - 1;

  logic [27:0]        eaReg;
  logic               userReg;
  logic [SEG_W-1:0]   segReg;
  logic [ENTRY_W-1:0] entryIdx;
  logic               onSecondary;
  logic               wordIsLow;
  logic [WORD_W-1:0]  rdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaReg       <= '0;
      userReg     <= 1'b0;
      segReg      <= '0;
      entryIdx    <= '0;
      onSecondary <= 1'b0;
      wordIsLow   <= 1'b0;
      rdWord      <= '0;
    end else begin
      if (ctl.start) begin
        eaReg       <= reqAddr[27:0];
        userReg     <= reqUser;
        segReg      <= segTable[int'(reqAddr[31:28])*SEG_W +: SEG_W];
        entryIdx    <= '0;
        onSecondary <= 1'b0;
        wordIsLow   <= 1'b0;
      end
      if (ctl.capture)     rdWord <= memRdata;
      if (ctl.toLow)       wordIsLow <= 1'b1;
      if (ctl.nextEntry) begin
        entryIdx  <= entryIdx + 1'b1;
        wordIsLow <= 1'b0;
      end
      if (ctl.toSecondary) begin
        entryIdx    <= '0;
        wordIsLow   <= 1'b0;
        onSecondary <= 1'b1;
      end
    end
  end

  // hashing and tag construction
  logic [27:0]       vsn;
  logic              supKey, usrKey, keyBit;
  logic [WORD_W-1:0] hashRaw, hashSel, hashMask, groupBase, entryAddr, tagWord;

  always_comb begin
    vsn       = segReg[27:0];
    supKey    = segReg[29];
    usrKey    = segReg[28];
    keyBit    = userReg ? usrKey : supKey;
    hashRaw   = ({4'b0, vsn} ^ {16'b0, eaReg[27:12]}) << 6;
    hashSel   = onSecondary ? ~hashRaw : hashRaw;
    hashMask  = {7'b0, tableMask, 16'hFFC0};
    groupBase = {tableBase, 16'h0} | (hashSel & hashMask);
    entryAddr = groupBase + (32'(entryIdx) << ENTRY_SHIFT) + (wordIsLow ? 32'd4 : 32'd0);
    tagWord   = 32'h8000_0000 | ({4'b0, vsn} << 7) | {25'b0, onSecondary, eaReg[27:22]};
  end

  logic [1:0] permBits;
  assign permBits  = decodePerm({keyBit, rdWord[1:0]});
  assign permRead  = permBits[1];
  assign permWrite = permBits[0];
  assign physAddr  = {rdWord[31:12], eaReg[11:0]};

  always_comb begin
    case (ctl.addrSel)
      MA_REF: begin
        memAddr  = entryAddr + 32'd2;
        memWdata = rdWord[15:8] | 8'h01;
      end
      MA_CHG: begin
        memAddr  = entryAddr + 32'd3;
        memWdata = rdWord[7:0] | 8'h80;
      end
      default: begin
        memAddr  = entryAddr;
        memWdata = 8'h00;
      end
    endcase
  end

  always_comb begin
    stat             = '0;
    stat.tagMatch    = (rdWord == tagWord);
    stat.permNone    = !permBits[1];
    stat.needRef     = !rdWord[REF_BIT];
    stat.needChg     = permBits[0] && !rdWord[CHG_BIT];
    stat.lastEntry   = (entryIdx == ENTRY_W'(LAST_ENTRY));
    stat.onSecondary = onSecondary;
    stat.wordIsLow   = wordIsLow;
  end
endmodule

// File: rtl/hpt_ctrl.sv
`timescale 1ns/1ps
module hpt_ctrl import hpt_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  walkStat_t stat,
  input  logic      memAck,
  output walkCtl_t  ctl,
  output logic      memReq,
  output logic      memWrite,
  output logic      reqReady,
  output logic      walkDone,
  output logic      walkFault
);
  walkState_t state, nextState;
  logic       wbChg, wbNext;
  logic       advance;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      wbChg <= 1'b0;
    end else begin
      state <= nextState;
      wbChg <= wbNext;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.addrSel = MA_READ;
    nextState   = state;
    wbNext      = wbChg;
    memReq      = 1'b0;
    memWrite    = 1'b0;
    advance     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.start = 1'b1;
          nextState = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          ctl.capture = 1'b1;
          nextState   = ST_COMPARE;
        end
      end
      ST_COMPARE: begin
        if (!stat.wordIsLow) begin
          if (stat.tagMatch) begin
            ctl.toLow = 1'b1;
            nextState = ST_FETCH;
          end else begin
            advance = 1'b1;
          end
        end else if (stat.permNone) begin
          advance = 1'b1;
        end else if (stat.needRef) begin
          wbNext    = 1'b0;
          nextState = ST_WRITEBACK;
        end else if (stat.needChg) begin
          wbNext    = 1'b1;
          nextState = ST_WRITEBACK;
        end else begin
          nextState = ST_DONE;
        end
        if (advance) begin
          if (!stat.lastEntry) begin
            ctl.nextEntry = 1'b1;
            nextState     = ST_FETCH;
          end else if (!stat.onSecondary) begin
            ctl.toSecondary = 1'b1;
            nextState       = ST_FETCH;
          end else begin
            nextState = ST_FAULT;
          end
        end
      end
      ST_WRITEBACK: begin
        memReq      = 1'b1;
        memWrite    = 1'b1;
        ctl.addrSel = wbChg ? MA_CHG : MA_REF;
        if (memAck) begin
          if (!wbChg && stat.needChg) wbNext = 1'b1;
          else                        nextState = ST_DONE;
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      ST_FAULT: nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  assign reqReady  = (state == ST_IDLE);
  assign walkDone  = (state == ST_DONE) || (state == ST_FAULT);
  assign walkFault = (state == ST_FAULT);
endmodule

// File: rtl/hpt_walker.sv
`timescale 1ns/1ps
module hpt_walker import hpt_pkg::*; #(
  parameter int GROUP_ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  output logic                       reqReady,
  input  logic [31:0]                reqAddr,
  input  logic                       reqUser,
  input  logic [SEG_COUNT*SEG_W-1:0] segTable,
  input  logic [15:0]                tableBase,
  input  logic [8:0]                 tableMask,
  output logic                       memReq,
  output logic                       memWrite,
  output logic [31:0]                memAddr,
  output logic [7:0]                 memWdata,
  input  logic [31:0]                memRdata,
  input  logic                       memAck,
  output logic                       walkDone,
  output logic                       walkFault,
  output logic [31:0]                physAddr,
  output logic                       canRead,
  output logic                       canWrite
);
  walkCtl_t  ctl;
  walkStat_t stat;
  logic      permRead, permWrite;

  hpt_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .stat, .memAck, .ctl,
    .memReq, .memWrite, .reqReady, .walkDone, .walkFault
  );

  hpt_dpath #(.GROUP_ENTRIES(GROUP_ENTRIES)) u_dpath (
    .clk, .rstN, .ctl, .stat, .reqAddr, .reqUser, .segTable,
    .tableBase, .tableMask, .memRdata, .memAddr, .memWdata,
    .physAddr, .permRead, .permWrite
  );

  assign canRead  = walkDone && !walkFault && permRead;
  assign canWrite = walkDone && !walkFault && permWrite;
endmodule

// File: rtl/hpt_walker_chk.sv
`timescale 1ns/1ps
module hpt_walker_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqReady,
  input logic        memReq,
  input logic        memWrite,
  input logic        memAck,
  input logic [31:0] memAddr,
  input logic [7:0]  memWdata,
  input logic        walkDone,
  input logic        walkFault,
  input logic        canRead,
  input logic        canWrite
);
  p_busy_no_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !reqReady);

  p_done_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    walkDone |=> !walkDone);

  p_write_implies_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    canWrite |-> canRead);

  p_fault_no_perm_r8: assert property (@(posedge clk) disable iff (!rstN)
    walkFault |-> (walkDone && !canRead && !canWrite));

  p_flag_byte_lane_r9: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWrite) |-> (memAddr[1] && (memAddr[0] ? memWdata[7] : memWdata[0])));

  p_hold_request_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWrite) && $stable(memWdata)));
endmodule

bind hpt_walker hpt_walker_chk u_chk (.*);

// File: tb/sim_hpt_walker.sv
`timescale 1ns/1ps
module sim_hpt_walker;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [31:0]  reqAddr = '0;
  logic         reqUser = 1'b0;
  logic [479:0] segTable = '0;
  logic [15:0]  tableBase = '0;
  logic [8:0]   tableMask = '0;
  logic         memReq, memWrite;
  logic [31:0]  memAddr;
  logic [7:0]   memWdata;
  logic [31:0]  memRdata = '0;
  logic         memAck = 1'b0;
  logic         walkDone, walkFault, canRead, canWrite;
  logic [31:0]  physAddr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  hpt_walker u0 (
    .clk, .rstN, .reqValid, .reqReady, .reqAddr, .reqUser, .segTable,
    .tableBase, .tableMask, .memReq, .memWrite, .memAddr, .memWdata,
    .memRdata, .memAck, .walkDone, .walkFault, .physAddr, .canRead, .canWrite
  );

  // memory model: word array, big-endian byte lanes
  logic [31:0] memArr [int unsigned];
  int          latency = 1;
  int          waitCnt = 0;
  int          rdCount = 0;
  int          wrCount = 0;
  logic [31:0] wrAddrLog [4];
  logic [7:0]  wrDataLog [4];

  always @(posedge clk) begin
    memAck <= 1'b0;
    if (rstN && memReq && !memAck) begin
      if (waitCnt + 1 >= latency) begin
        waitCnt = 0;
        memAck <= 1'b1;
        if (memWrite) begin
          logic [31:0] w;
          int unsigned idx;
          idx = memAddr >> 2;
          w = memArr.exists(idx) ? memArr[idx] : 32'h0;
          w[(3 - int'(memAddr[1:0]))*8 +: 8] = memWdata;
          memArr[idx] = w;
          if (wrCount < 4) begin
            wrAddrLog[wrCount] = memAddr;
            wrDataLog[wrCount] = memWdata;
          end
          wrCount++;
        end else begin
          memRdata <= memArr.exists(memAddr >> 2) ? memArr[memAddr >> 2] : 32'h0;
          rdCount++;
        end
      end else begin
        waitCnt++;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expGroup(input logic [27:0] vsn, input logic [31:0] ea,
                                           input logic [15:0] base, input logic [8:0] msk,
                                           input logic sec);
    logic [31:0] h;
    h = ({4'b0, vsn} ^ {16'b0, ea[27:12]}) << 6;
    if (sec) h = ~h;
    return {base, 16'h0} | (h & {7'b0, msk, 16'hFFC0});
  endfunction

  function automatic logic [31:0] expTag(input logic [27:0] vsn, input logic [31:0] ea,
                                         input logic sec);
    return 32'h8000_0000 | ({4'b0, vsn} << 7) | (sec ? 32'h40 : 32'h0) | {26'b0, ea[27:22]};
  endfunction

  task automatic setSeg(input int idx, input logic supK, input logic usrK, input logic [27:0] vsn);
    segTable[idx*30 +: 30] = {supK, usrK, vsn};
  endtask

  task automatic putEntry(input logic [31:0] grp, input int idx,
                          input logic [31:0] w0, input logic [31:0] w1);
    memArr[(grp + 32'(idx*8)) >> 2]     = w0;
    memArr[(grp + 32'(idx*8) + 4) >> 2] = w1;
  endtask

  function automatic logic [31:0] peek(input logic [31:0] addr);
    return memArr.exists(addr >> 2) ? memArr[addr >> 2] : 32'h0;
  endfunction

  logic        resFault, resRead, resWrite, busyReady;
  logic [31:0] resPhys;

  task automatic clearMem();
    memArr.delete();
    rdCount = 0;
    wrCount = 0;
  endtask

  task automatic runWalk(input logic [31:0] ea, input logic user);
    int n;
    @(negedge clk);
    reqAddr  = ea;
    reqUser  = user;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid  = 1'b0;
    busyReady = reqReady;
    n = 0;
    while (!walkDone && n < 2000) begin
      @(negedge clk);
      n++;
    end
    resFault = walkFault;
    resRead  = canRead;
    resWrite = canWrite;
    resPhys  = physAddr;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "reqReady after reset", 32'(reqReady), 32'd1);
    chk("R1", "walkDone after reset", 32'(walkDone), 32'd0);
    chk("R1", "memReq after reset", 32'(memReq), 32'd0);
  endtask

  // R2 R4 R9 R10: primary hit, entry 0, read/write, both flags clear
  task automatic t_primaryHit(input int lat);
    logic [27:0] v;
    logic [31:0] ea, grp;
    v = 28'h0123456;
    ea = 32'h3ABC_D123;
    latency = lat;
    clearMem();
    tableBase = 16'h0010;
    tableMask = 9'h0;
    setSeg(3, 1'b0, 1'b0, v);
    grp = expGroup(v, ea, 16'h0010, 9'h0, 1'b0);
    putEntry(grp, 0, expTag(v, ea, 1'b0), 32'h0005_6002);
    runWalk(ea, 1'b0);
    chk("R1", "reqReady low while busy", 32'(busyReady), 32'd0);
    chk("R4", "physAddr", resPhys, 32'h0005_6123);
    chk("R5", "read/write code 2", {30'b0, resRead, resWrite}, 32'd3);
    chk("R2", "no fault at primary group", 32'(resFault), 32'd0);
    chk("R9", "write count", 32'(wrCount), 32'd2);
    chk("R9", "ref byte addr", wrAddrLog[0], grp + 32'd6);
    chk("R9", "ref byte data", 32'(wrDataLog[0]), 32'h61);
    chk("R10", "chg byte addr", wrAddrLog[1], grp + 32'd7);
    chk("R10", "chg byte data", 32'(wrDataLog[1]), 32'h82);
    chk("R12", "entry word after update", peek(grp + 32'd4), 32'h0005_6182);
    latency = 1;
  endtask

  // R3 R5 R11: two matches, first wins; key set gives read only; flags set
  task automatic t_entryOrder();
    logic [27:0] v;
    logic [31:0] ea, grp;
    v = 28'h0ABCDEF;
    ea = 32'h5123_4567;
    clearMem();
    tableBase = 16'h0020;
    tableMask = 9'h0;
    setSeg(5, 1'b1, 1'b0, v);
    grp = expGroup(v, ea, 16'h0020, 9'h0, 1'b0);
    putEntry(grp, 1, 32'h8000_0001, 32'h7777_7002);
    putEntry(grp, 3, expTag(v, ea, 1'b0), 32'h1111_1101);
    putEntry(grp, 5, expTag(v, ea, 1'b0), 32'h2222_2182);
    runWalk(ea, 1'b0);
    chk("R3", "first match in order wins", resPhys, 32'h1111_1567);
    chk("R5", "code 5 read only", {30'b0, resRead, resWrite}, 32'd2);
    chk("R11", "no writes with ref set on read-only hit", 32'(wrCount), 32'd0);
    chk("R3", "reads: tags 0..3 plus one second word", 32'(rdCount), 32'd5);
  endtask

  // R6 R5 R10: code 4 skipped, later code 7 read only with ref clear
  task automatic t_keySkip();
    logic [27:0] v;
    logic [31:0] ea, grp;
    v = 28'h0F0F0F0;
    ea = 32'h9876_5FFF;
    clearMem();
    tableBase = 16'h0030;
    tableMask = 9'h0;
    setSeg(9, 1'b0, 1'b1, v);
    grp = expGroup(v, ea, 16'h0030, 9'h0, 1'b0);
    putEntry(grp, 1, expTag(v, ea, 1'b0), 32'h6666_6000);
    putEntry(grp, 6, expTag(v, ea, 1'b0), 32'h3333_3003);
    runWalk(ea, 1'b1);
    chk("R6", "code 4 entry passed over", resPhys, 32'h3333_3FFF);
    chk("R5", "code 7 read only", {30'b0, resRead, resWrite}, 32'd2);
    chk("R10", "read-only hit writes only ref byte", 32'(wrCount), 32'd1);
    chk("R9", "ref byte data", 32'(wrDataLog[0]), 32'h31);
    chk("R11", "code 4 entry untouched", peek(grp + 32'd12), 32'h6666_6000);
  endtask

  // R7: primary empty, secondary entry 7 hits
  task automatic t_secondary();
    logic [27:0] v;
    logic [31:0] ea, pgrp, sgrp;
    v = 28'h0000ACE;
    ea = 32'h0001_2345;
    clearMem();
    tableBase = 16'h0040;
    tableMask = 9'h0;
    setSeg(0, 1'b0, 1'b1, v);
    pgrp = expGroup(v, ea, 16'h0040, 9'h0, 1'b0);
    sgrp = expGroup(v, ea, 16'h0040, 9'h0, 1'b1);
    putEntry(pgrp, 2, expTag(v, ea, 1'b1), 32'h9999_9182);
    putEntry(sgrp, 7, expTag(v, ea, 1'b1), 32'h4444_4182);
    runWalk(ea, 1'b0);
    chk("R7", "secondary hit physAddr", resPhys, 32'h4444_4345);
    chk("R7", "reads 8 primary + 8 secondary + 1", 32'(rdCount), 32'd17);
    chk("R5", "code 2 read/write", {30'b0, resRead, resWrite}, 32'd3);
    chk("R11", "flags set, no writes", 32'(wrCount), 32'd0);
  endtask

  // R8: both groups empty
  task automatic t_fault();
    clearMem();
    setSeg(7, 1'b0, 1'b0, 28'h0333333);
    runWalk(32'h7000_1000, 1'b0);
    chk("R8", "fault flag", 32'(resFault), 32'd1);
    chk("R8", "no permission on fault", {30'b0, resRead, resWrite}, 32'd0);
    chk("R8", "tag reads on fault", 32'(rdCount), 32'd16);
    chk("R8", "no writes on fault", 32'(wrCount), 32'd0);
    chk("R1", "ready after fault", 32'(reqReady), 32'd1);
  endtask

  // R2 R10: full mask, changed-only write
  task automatic t_mask();
    logic [27:0] v;
    logic [31:0] ea, grp;
    v = 28'hFEDCBA9;
    ea = 32'hF123_4ABC;
    clearMem();
    tableBase = 16'h0E00;
    tableMask = 9'h1FF;
    setSeg(15, 1'b0, 1'b0, v);
    grp = expGroup(v, ea, 16'h0E00, 9'h1FF, 1'b0);
    putEntry(grp, 2, expTag(v, ea, 1'b0), 32'h5555_5100);
    runWalk(ea, 1'b0);
    chk("R2", "masked group hit", resPhys, 32'h5555_5ABC);
    chk("R10", "only chg write", 32'(wrCount), 32'd1);
    chk("R10", "chg addr", wrAddrLog[0], grp + 32'd16 + 32'd7);
    chk("R10", "chg data", 32'(wrDataLog[0]), 32'h80);
    tableMask = 9'h0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_primaryHit(1);
    t_entryOrder();
    t_keySkip();
    t_secondary();
    t_fault();
    t_mask();
    t_primaryHit(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule